// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescing Controller

This block holds the control and status words of one descriptor-driven DMA channel and decides when that channel interrupts the processor. The transfer engine pulses a completion strobe once per finished packet. Instead of interrupting on every packet, the block counts completions down from a programmable threshold. It also runs an inactivity timer that restarts on each completion. An interrupt is raised when the threshold is reached or when the timer runs out, so a trickle of packets still gets serviced.

Software reaches the block through a single-word register port. Address 0 selects the control word and address 1 selects the status word. Status reads return the live completion counter and timer value. The block drives the run and soft-reset indications for the engine and reports the halted and idle state. The engine's "tail pointer written" event clears idle. The timer advances on a prescaled tick input.

Top module: `dic_top`

## Requirements
- R1: After reset the control word reads 0x0001_0002, the status word reads 0x0001_0001, halted is 1, and run, idle, soft reset and irq are 0. The completion counter is 1 and the timer is 0.
- R2: Control bit 1 always reads as 1. Every other written control bit reads back as written, except bit 2.
- R3: A control write reloads the completion counter from bits 23:16 of the written word. If that write has bit 0 set and bit 2 clear, it also clears halted and idle and sets run. With bit 2 set, halted stays 1 and run is 0.
- R4: A control write with bit 2 set returns the control word to its reset value and the status word to halted only. It sets the counter to 1, clears the timer, and raises soft reset. The first register access after that write clears soft reset. A control read never shows bit 2 set.
- R5: Each completion strobe decrements the counter. When the counter reaches 0, status bit 12 sets and the counter reloads from control bits 23:16.
- R6: When control bits 31:24 are non-zero, a completion strobe loads that value into the timer. Each tick decrements a non-zero timer. The timer never goes below 0, and it stays at 0 when the delay field is 0.
- R7: When a tick takes the timer from 1 to 0, status bit 13 sets and the counter reloads from the threshold.
- R8: irq is 1 exactly when some status bit in 14:12 is set together with the control bit at the same position.
- R9: A status write clears each bit of 14:12 written as 1, and loads halted (bit 0) and idle (bit 1) from the written value. An interrupt event in the same cycle wins over the clear.
- R10: A status read returns the timer in bits 31:24, the counter in bits 23:16, the pending interrupts in 14:12, idle in bit 1 and halted in bit 0. All other bits read 0.
- R11: The tail-written pulse clears idle.
- R12: Read data is valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| pkt_done | input | 1 | One-cycle packet completion strobe |
| tail_written | input | 1 | Tail pointer was written; clears idle |
| delay_tick | input | 1 | Prescaled tick for the delay timer |
| run_o | output | 1 | Channel run request |
| soft_rst_o | output | 1 | Soft reset in progress |
| halted_o | output | 1 | Channel halted |
| idle_o | output | 1 | Channel idle |
| cmpl_cnt_o | output | 8 | Live completion counter |
| dly_cnt_o | output | 8 | Live delay timer |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench restarts the timer with a second completion just before it would expire. A design that reloads only from idle would instead fire the delay interrupt early. It clears a pending completion interrupt in the same cycle that a new one arrives, and a design that gives the clear priority would lose an interrupt. It also checks that a pending interrupt with its enable clear leaves irq low and raises it once the enable is written, that the timer holds at 0 under further ticks, and that soft reset clears on the following read rather than immediately or never.

// File: rtl/dic_pkg.sv
package dic_pkg;
   localparam int REG_W    = 32;
   localparam int B_RUN    = 0;
   localparam int B_TAILM  = 1;
   localparam int B_SRST   = 2;
   localparam int B_HALT   = 0;
   localparam int B_IDLE   = 1;
   localparam int IRQ_LO   = 12;
   localparam int IRQ_N    = 3;
   localparam int THR_LO   = 16;
   localparam int DLY_LO   = 24;
   localparam int FIELD_W  = 8;
   localparam logic [REG_W-1:0] CTRL_DEFAULT = 32'h0001_0002;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/dic_ctrl_reg.sv
module dic_ctrl_reg
   import dic_pkg::*;
#(
   parameter int THR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              any_acc,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  ctrl_q,
   output logic              srst_pend,
   output logic              reload,
   output logic [THR_W-1:0]  reload_val,
   output logic              srst_evt,
   output logic              start_evt
);
   logic [REG_W-1:0] word_q;
   logic             pend_q;

   assign srst_evt   = wr_ctrl & wdata[B_SRST];
   assign start_evt  = wr_ctrl & wdata[B_RUN] & ~wdata[B_SRST];
   assign reload     = wr_ctrl;
   assign reload_val = wdata[B_SRST] ? THR_W'(1) : wdata[THR_LO +: THR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= CTRL_DEFAULT;
         pend_q <= 1'b0;
      end else if (wr_ctrl) begin
         if (wdata[B_SRST]) begin
            word_q <= CTRL_DEFAULT;
            pend_q <= 1'b1;
         end else begin
            word_q         <= wdata;
            word_q[B_TAILM] <= 1'b1;
            pend_q         <= 1'b0;
         end
      end else if (any_acc) begin
         pend_q <= 1'b0;
      end
   end

   assign ctrl_q    = word_q;
   assign srst_pend = pend_q;
endmodule

// File: rtl/dic_coalesce.sv
module dic_coalesce #(
   parameter int THR_W = 8,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [THR_W-1:0] reload_val,
   input  logic             srst,
   input  logic             pkt_done,
   input  logic             tick,
   input  logic [THR_W-1:0] thr,
   input  logic [DLY_W-1:0] dly,
   output logic [THR_W-1:0] cnt,
   output logic [DLY_W-1:0] tmr,
   output logic             ioc_set,
   output logic             dly_set
);
   localparam logic [THR_W-1:0] CNT_ONE = THR_W'(1);
   localparam logic [DLY_W-1:0] TMR_ONE = DLY_W'(1);

   logic [THR_W-1:0] cnt_q;
   logic [DLY_W-1:0] tmr_q;
   logic             restart;
   logic             expire;

   assign restart = pkt_done && (dly != '0);
   assign expire  = tick && (tmr_q == TMR_ONE) && !restart && !srst;
   assign ioc_set = pkt_done && !reload && (cnt_q == CNT_ONE);
   assign dly_set = expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q <= '0;
      end else if (srst) begin
         tmr_q <= '0;
      end else if (restart) begin
         tmr_q <= dly;
      end else if (tick && (tmr_q != '0)) begin
         tmr_q <= tmr_q - TMR_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_ONE;
      end else if (reload) begin
         cnt_q <= reload_val;
      end else if (pkt_done) begin
         cnt_q <= (cnt_q == CNT_ONE) ? thr : cnt_q - CNT_ONE;
      end else if (expire) begin
         cnt_q <= thr;
      end
   end

   assign cnt = cnt_q;
   assign tmr = tmr_q;
endmodule

// File: rtl/dic_status.sv
module dic_status
   import dic_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stat,
   input  logic [1:0]       wr_state,
   input  logic [IRQ_N-1:0] wr_clr,
   input  logic             ioc_set,
   input  logic             dly_set,
   input  logic             srst,
   input  logic             start,
   input  logic             tail_wr,
   output logic             halted,
   output logic             idle,
   output logic [IRQ_N-1:0] pend
);
   logic             halt_q, idle_q;
   logic [IRQ_N-1:0] pend_q, pend_set;

   always_comb begin
      pend_set    = '0;
      pend_set[0] = ioc_set;
      pend_set[1] = dly_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b1;
         idle_q <= 1'b0;
         pend_q <= '0;
      end else if (srst) begin
         halt_q <= 1'b1;
         idle_q <= 1'b0;
         pend_q <= '0;
      end else begin
         if (wr_stat) begin
            halt_q <= wr_state[B_HALT];
            idle_q <= wr_state[B_IDLE] & ~tail_wr;
            pend_q <= (pend_q & ~wr_clr) | pend_set;
         end else begin
            if (start) begin
               halt_q <= 1'b0;
               idle_q <= 1'b0;
            end else if (tail_wr) begin
               idle_q <= 1'b0;
            end
            pend_q <= pend_q | pend_set;
         end
      end
   end

   assign halted = halt_q;
   assign idle   = idle_q;
   assign pend   = pend_q;
endmodule

// File: rtl/dic_top.sv
module dic_top
   import dic_pkg::*;
#(
   parameter int THR_W     = 8,
   parameter int DLY_W     = 8,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic        reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        pkt_done,
   input  logic        tail_written,
   input  logic        delay_tick,
   output logic        run_o,
   output logic        soft_rst_o,
   output logic        halted_o,
   output logic        idle_o,
   output logic [7:0]  cmpl_cnt_o,
   output logic [7:0]  dly_cnt_o,
   output logic        irq_o
);
   generate
      if (THR_W < 1 || THR_W > FIELD_W) begin : g_bad_thr
         $error("THR_W must lie in 1..8");
      end
      if (DLY_W < 1 || DLY_W > FIELD_W) begin : g_bad_dly
         $error("DLY_W must lie in 1..8");
      end
   endgenerate

   logic             wr_ctrl, wr_stat, any_acc;
   logic [REG_W-1:0] ctrl_q;
   logic             srst_pend, reload, srst_evt, start_evt;
   logic [THR_W-1:0] reload_val, cnt;
   logic [DLY_W-1:0] tmr;
   logic             ioc_set, dly_set;
   logic             halted, idle;
   logic [IRQ_N-1:0] pend;
   logic [7:0]       cnt8, tmr8;
   logic [REG_W-1:0] stat_img, rd_img;

   assign wr_ctrl = reg_wr && (reg_sel_e'(reg_addr) == SEL_CTRL);
   assign wr_stat = reg_wr && (reg_sel_e'(reg_addr) == SEL_STAT);
   assign any_acc = reg_wr || reg_rd;

   dic_ctrl_reg #(.THR_W(THR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (wr_ctrl),
      .any_acc    (any_acc),
      .wdata      (reg_wdata),
      .ctrl_q     (ctrl_q),
      .srst_pend  (srst_pend),
      .reload     (reload),
      .reload_val (reload_val),
      .srst_evt   (srst_evt),
      .start_evt  (start_evt)
   );

   dic_coalesce #(.THR_W(THR_W), .DLY_W(DLY_W)) u_coal (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload     (reload),
      .reload_val (reload_val),
      .srst       (srst_evt),
      .pkt_done   (pkt_done),
      .tick       (delay_tick),
      .thr        (ctrl_q[THR_LO +: THR_W]),
      .dly        (ctrl_q[DLY_LO +: DLY_W]),
      .cnt        (cnt),
      .tmr        (tmr),
      .ioc_set    (ioc_set),
      .dly_set    (dly_set)
   );

   dic_status u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stat  (wr_stat),
      .wr_state (reg_wdata[1:0]),
      .wr_clr   (reg_wdata[IRQ_LO +: IRQ_N]),
      .ioc_set  (ioc_set),
      .dly_set  (dly_set),
      .srst     (srst_evt),
      .start    (start_evt),
      .tail_wr  (tail_written),
      .halted   (halted),
      .idle     (idle),
      .pend     (pend)
   );

   always_comb begin
      cnt8 = '0;
      tmr8 = '0;
      cnt8[THR_W-1:0] = cnt;
      tmr8[DLY_W-1:0] = tmr;
   end

   assign stat_img = {tmr8, cnt8, 1'b0, pend, 10'b0, idle, halted};
   assign rd_img   = (reg_sel_e'(reg_addr) == SEL_CTRL) ? ctrl_q : stat_img;

   generate
      if (REG_RDATA) begin : g_rd_reg
         logic [REG_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata_q <= '0;
            end else if (reg_rd) begin
               rdata_q <= rd_img;
            end
         end
         assign reg_rdata = rdata_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_img;
      end
   endgenerate

   assign run_o      = ctrl_q[B_RUN];
   assign soft_rst_o = srst_pend;
   assign halted_o   = halted;
   assign idle_o     = idle;
   assign cmpl_cnt_o = cnt8;
   assign dly_cnt_o  = tmr8;
   assign irq_o      = |(pend & ctrl_q[IRQ_LO +: IRQ_N]);
endmodule

// File: rtl/dic_chk.sv
module dic_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        reg_rd,
   input logic        reg_addr,
   input logic [31:0] reg_wdata,
   input logic        pkt_done,
   input logic        tail_written,
   input logic        delay_tick,
   input logic        run_o,
   input logic        soft_rst_o,
   input logic        halted_o,
   input logic        idle_o,
   input logic [7:0]  cmpl_cnt_o,
   input logic [7:0]  dly_cnt_o,
   input logic        irq_o
);
   logic ctrl_wr;
   assign ctrl_wr = reg_wr && !reg_addr;

   p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && reg_wdata[0] && !reg_wdata[2]) |=> (run_o && !halted_o && !idle_o));

   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !reg_wdata[2]) |=> (cmpl_cnt_o == $past(reg_wdata[23:16])));

   p_srst_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && reg_wdata[2]) |=>
         (halted_o && !idle_o && !run_o && !irq_o && soft_rst_o &&
          dly_cnt_o == 8'd0 && cmpl_cnt_o == 8'd1));

   p_srst_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst_o && (reg_rd || reg_wr) && !(ctrl_wr && reg_wdata[2])) |=> !soft_rst_o);

   p_tmr_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_cnt_o == 8'd0 && !pkt_done && !ctrl_wr) |=> (dly_cnt_o == 8'd0));

   p_tmr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (delay_tick && dly_cnt_o > 8'd1 && !pkt_done && !ctrl_wr) |=>
         (dly_cnt_o == $past(dly_cnt_o) - 8'd1));

   p_tail_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tail_written |=> !idle_o);
endmodule

bind dic_top dic_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_rd       (reg_rd),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .pkt_done     (pkt_done),
   .tail_written (tail_written),
   .delay_tick   (delay_tick),
   .run_o        (run_o),
   .soft_rst_o   (soft_rst_o),
   .halted_o     (halted_o),
   .idle_o       (idle_o),
   .cmpl_cnt_o   (cmpl_cnt_o),
   .dly_cnt_o    (dly_cnt_o),
   .irq_o        (irq_o)
);

// File: tb/dic_top_tb.sv
`timescale 1ns/1ps
module dic_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pkt_done = 1'b0, tail_written = 1'b0, delay_tick = 1'b0;
   logic        run_o, soft_rst_o, halted_o, idle_o, irq_o;
   logic [7:0]  cmpl_cnt_o, dly_cnt_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #2.5 clk = ~clk;

   dic_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pkt_done(pkt_done), .tail_written(tail_written), .delay_tick(delay_tick),
      .run_o(run_o), .soft_rst_o(soft_rst_o), .halted_o(halted_o),
      .idle_o(idle_o), .cmpl_cnt_o(cmpl_cnt_o), .dly_cnt_o(dly_cnt_o),
      .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: read data is due the cycle after the strobe (R12)
   always @(posedge clk) rd_seen <= reg_rd && rst_n;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R12: unexpected read data %h expected none", reg_rdata);
         end else begin
            chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic wr(input logic a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic done(input int n);
      for (int i = 0; i < n; i++) begin
         pkt_done = 1'b1; @(negedge clk); pkt_done = 1'b0;
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         delay_tick = 1'b1; @(negedge clk); delay_tick = 1'b0;
      end
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 halted", halted_o, 1);
      chk("R1 idle", idle_o, 0);
      chk("R1 run", run_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 soft", soft_rst_o, 0);
      chk("R1 cnt", cmpl_cnt_o, 1);
      chk("R1 tmr", dly_cnt_o, 0);
      rd(0, 32'h0001_0002, "R1 ctrl read");
      rd(1, 32'h0001_0001, "R1 R10 R12 status read");

      // R2 tail-mode bit forced; R3 reload without run
      wr(0, 32'h0000_0000);
      rd(0, 32'h0000_0002, "R2 ctrl zero write");
      chk("R3 cnt reload 0", cmpl_cnt_o, 0);
      chk("R3 still halted", halted_o, 1);

      wr(0, 32'h0003_1001);
      chk("R3 run", run_o, 1);
      chk("R3 halted cleared", halted_o, 0);
      chk("R3 cnt", cmpl_cnt_o, 3);
      rd(0, 32'h0003_1003, "R2 ctrl readback");

      // R5 threshold counting
      done(2);
      chk("R5 cnt after 2", cmpl_cnt_o, 1);
      chk("R5 no irq yet", irq_o, 0);
      rd(1, 32'h0001_0000, "R10 status mid count");
      done(1);
      chk("R5 reload", cmpl_cnt_o, 3);
      chk("R8 irq on ioc", irq_o, 1);
      rd(1, 32'h0003_1000, "R5 status ioc");

      // R9 write-one-to-clear and state bits
      wr(1, 32'h0000_1000);
      chk("R9 cleared irq", irq_o, 0);
      wr(1, 32'h0000_0003);
      chk("R9 halted written", halted_o, 1);
      chk("R9 idle written", idle_o, 1);
      tail_written = 1'b1; @(negedge clk); tail_written = 1'b0;
      chk("R11 idle cleared", idle_o, 0);
      chk("R11 halted kept", halted_o, 1);

      // R8 enable gating
      wr(0, 32'h0003_0001);
      done(3);
      chk("R8 masked", irq_o, 0);
      rd(1, 32'h0003_1000, "R8 pending while masked");
      wr(0, 32'h0003_1001);
      chk("R8 enable raises irq", irq_o, 1);
      wr(1, 32'h0000_1000);
      chk("R9 clear again", irq_o, 0);

      // R6 R7 delay timer
      wr(0, 32'h0405_2001);
      done(1);
      chk("R6 timer load", dly_cnt_o, 4);
      tick(3);
      rd(1, 32'h0104_0000, "R10 R6 status timer");
      done(1);
      chk("R6 restart", dly_cnt_o, 4);
      chk("R5 cnt 3", cmpl_cnt_o, 3);
      tick(3);
      chk("R6 no early irq", irq_o, 0);
      tick(1);
      chk("R7 expired", dly_cnt_o, 0);
      chk("R7 cnt reload", cmpl_cnt_o, 5);
      chk("R7 irq", irq_o, 1);
      tick(2);
      chk("R6 floor", dly_cnt_o, 0);
      rd(1, 32'h0005_2000, "R7 status delay irq");
      wr(1, 32'h0000_2000);

      // R9 set wins over clear in the same cycle
      wr(0, 32'h0001_1001);
      done(1);
      chk("R5 thr1 irq", irq_o, 1);
      reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h0000_1000; pkt_done = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; pkt_done = 1'b0;
      chk("R9 set wins", irq_o, 1);
      rd(1, 32'h0001_1000, "R9 status after collision");

      // R6 delay field zero keeps timer at 0
      wr(0, 32'h0002_1001);
      done(1);
      chk("R6 zero delay", dly_cnt_o, 0);
      tick(1);
      chk("R6 zero delay tick", dly_cnt_o, 0);

      // R4 soft reset
      wr(0, 32'h0302_2001);
      done(1);
      chk("R6 timer 3", dly_cnt_o, 3);
      wr(0, 32'hFF00_0005);
      chk("R4 soft", soft_rst_o, 1);
      chk("R4 halted", halted_o, 1);
      chk("R4 run", run_o, 0);
      chk("R4 cnt", cmpl_cnt_o, 1);
      chk("R4 tmr", dly_cnt_o, 0);
      chk("R4 irq", irq_o, 0);
      rd(0, 32'h0001_0002, "R4 ctrl after soft reset");
      chk("R4 soft cleared", soft_rst_o, 0);
      rd(1, 32'h0001_0001, "R4 status after soft reset");

      // R3 run with reset set does not start
      wr(0, 32'h0000_0005);
      chk("R3 run+reset halted", halted_o, 1);
      chk("R3 run+reset run", run_o, 0);
      rd(0, 32'h0001_0002, "R4 ctrl bit2 hidden");

      repeat (3) @(negedge clk);
      chk("R12 scoreboard drained", exp_q.size(), 0);
      summary();
   end
endmodule